// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor load/store port and a main memory that delivers data in bursts. It keeps 256 lines of sixteen 32-bit words. Each line has a valid flag and an 18-bit tag. An access that hits is served in the same cycle: a load gets the addressed word on `cpu_rdata`, and a store updates that word. An access that misses raises `cpu_stall`. The controller then asks memory for the whole line in one burst, writes the words into the line as they arrive, and marks the line valid. The requester keeps its access presented the whole time, and the access completes as a hit once the line is in place.

Stores are write-through. Every completed store also places its word address and data into a small posted queue, and the queue drains to memory through a request/acknowledge pair. The queue and the line fill share the memory side. A fill is not started until the queue is empty, and the queue does not drain while a fill is in progress. A store that finds the queue full is stalled until an entry leaves.

The requester holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until it sees a cycle with `cpu_stall` low. The access completes at the rising edge that ends that cycle.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset every line is invalid. With no request, `cpu_stall`, `mem_rd_req` and `mem_wr_req` are all low, and the first access to any line is a miss.
- R2: The address is split as tag = bits 31..14, line index = bits 13..6 and word select = bits 5..2. Bits 1..0 have no effect on which word is read or written.
- R3: An access hits when the indexed line is valid and its tag equals address bits 31..14. A hit is completed with `cpu_stall` low in the cycle it is presented, and a load returns the selected word on `cpu_rdata` in that same cycle.
- R4: On a miss, `cpu_stall` is high and `mem_rd_req` is raised with `mem_rd_line` = address bits 31..6. Both are held unchanged while `mem_rd_busy` is high. The burst is accepted on the first edge at which `mem_rd_busy` is low.
- R5: The k-th `mem_rd_valid` strobe of a burst (k = 0..15) writes `mem_rd_data` into word k of the line. After the 16th strobe the line is valid, and the held access then completes as a hit.
- R6: A store hit writes `cpu_wdata` into the addressed word, so a later load of that word returns it. It also enqueues a memory write whose address is `cpu_addr` with bits 1..0 cleared.
- R7: A store miss first fills the line from memory, then completes as a store hit. The written word is updated and the other words hold the memory contents.
- R8: The write queue holds 4 entries. A store presented while all 4 are occupied is stalled until an entry is acknowledged, and then completes.
- R9: Queued writes leave in store order, one per cycle in which `mem_wr_req` and `mem_wr_ack` are both high. `mem_wr_req` is never high while a burst is requested or arriving, and a miss does not raise `mem_rd_req` while the queue is not empty.
- R10: Two addresses with the same line index and different tags evict each other. Returning to the first one misses again and refetches the line, including any words that earlier stores wrote to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until it completes |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid in a cycle with the request high and the stall low |
| cpu_stall | output | 1 | Access cannot complete in this cycle |
| mem_rd_req | output | 1 | Burst line read request |
| mem_rd_line | output | 26 | Line address of the burst (byte address bits 31..6) |
| mem_rd_busy | input | 1 | Memory cannot take the burst request yet |
| mem_rd_valid | input | 1 | One burst word is present on `mem_rd_data` |
| mem_rd_data | input | 32 | Burst word, word 0 first |
| mem_wr_req | output | 1 | Head of the write queue is presented |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_ack | input | 1 | Memory takes the presented write |

## Verification
The bench uses same-index conflicts, and a design that compared the wrong address bits would report a hit where it should miss, or a miss where it should hit. It reads every word of a freshly filled line, which exposes a sequencer that counts strobes wrongly or writes word k to another slot. It stalls the write acknowledge to fill the queue, and this catches a controller that overruns the queue or accepts a fifth store. With writes still queued, it presents a miss, which exposes a fill that overtakes pending stores and then refetches stale data.

// File: rtl/cache_pkg.sv
package cache_pkg;
   localparam int ADDR_W = 32;
   localparam int DATA_W = 32;
   localparam int OFF_W  = 2;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } wq_entry_t;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_FILL = 2'd2
   } fill_state_t;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
   parameter int LINES = 256,
   parameter int TAG_W = 18,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             inv_en,
   input  logic             set_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_valid
      always_ff @(posedge clk) begin
         if (!rst_n)
            valid_q[g] <= 1'b0;
         else if (set_en && wr_idx == IDX_W'(g))
            valid_q[g] <= 1'b1;
         else if (inv_en && wr_idx == IDX_W'(g))
            valid_q[g] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (set_en) tag_q[wr_idx] <= wr_tag;
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];

   AST_VALID_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> valid_q[$past(wr_idx)]); // R5
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
   parameter int LINES  = 256,
   parameter int WORDS  = 16,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(LINES),
   localparam int WRD_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WRD_W-1:0]  rd_word,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WRD_W-1:0]  wr_word,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] words_q [LINES*WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) words_q[{wr_idx, wr_word}] <= wr_data;
   end

   assign rd_data = words_q[{rd_idx, rd_word}];
endmodule

// File: rtl/cache_wq.sv
module cache_wq #(
   parameter int DEPTH = 4,
   parameter int W     = 64,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         full,
   output logic         empty
);
   logic [W-1:0]     slot_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0] cnt_q;

   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cache_wq: DEPTH must be a power of two");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push) wr_ptr_q <= (DEPTH > 1) ? wr_ptr_q + 1'b1 : '0;
         if (pop)  rd_ptr_q <= (DEPTH > 1) ? rd_ptr_q + 1'b1 : '0;
         if (push && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) slot_q[wr_ptr_q] <= push_data;
   end

   assign head  = slot_q[rd_ptr_q];
   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign empty = (cnt_q == '0);

   AST_WQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R8
   AST_WQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R9
   AST_WQ_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH)); // R8
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
   import cache_pkg::*;
#(
   parameter int LINES    = 256,
   parameter int WORDS    = 16,
   parameter int WQ_DEPTH = 4,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WRD_W  = $clog2(WORDS),
   localparam int LINE_W = ADDR_W - WRD_W - OFF_W,
   localparam int TAG_W  = LINE_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_rd_req,
   output logic [LINE_W-1:0] mem_rd_line,
   input  logic              mem_rd_busy,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   input  logic              mem_wr_ack
);
   if ((LINES & (LINES - 1)) != 0 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_geom
      $error("dm_wt_cache: LINES and WORDS must be powers of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dm_wt_cache: address too narrow for geometry");
   end

   fill_state_t       state_q;
   logic [LINE_W-1:0] fill_line_q;
   logic [WRD_W-1:0]  fill_cnt_q;

   logic [TAG_W-1:0]  a_tag;
   logic [IDX_W-1:0]  a_idx;
   logic [WRD_W-1:0]  a_word;
   logic              line_valid, tag_match, hit, done, store_done;
   logic [TAG_W-1:0]  line_tag;
   logic              wq_full, wq_empty, wq_pop;
   wq_entry_t         wq_head, wq_in;
   logic              start_fill, fill_word, fill_last;
   logic              dwr_en;
   logic [IDX_W-1:0]  dwr_idx;
   logic [WRD_W-1:0]  dwr_word;
   logic [DATA_W-1:0] dwr_data;

   assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
   assign a_idx  = cpu_addr[OFF_W+WRD_W +: IDX_W];
   assign a_word = cpu_addr[OFF_W +: WRD_W];

   assign tag_match  = line_valid && (line_tag == a_tag);
   assign hit        = tag_match && (state_q == FS_IDLE);
   assign cpu_stall  = cpu_req && (!hit || (cpu_we && wq_full));
   assign done       = cpu_req && !cpu_stall;
   assign store_done = done && cpu_we;

   assign start_fill = (state_q == FS_IDLE) && cpu_req && !tag_match && wq_empty;
   assign fill_word  = (state_q == FS_FILL) && mem_rd_valid;
   assign fill_last  = fill_word && (fill_cnt_q == WRD_W'(WORDS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= FS_IDLE;
         fill_line_q <= '0;
         fill_cnt_q  <= '0;
      end else begin
         unique case (state_q)
            FS_IDLE: if (start_fill) begin
               fill_line_q <= cpu_addr[ADDR_W-1 -: LINE_W];
               state_q     <= FS_REQ;
            end
            FS_REQ: if (!mem_rd_busy) begin
               fill_cnt_q <= '0;
               state_q    <= FS_FILL;
            end
            FS_FILL: if (fill_word) begin
               fill_cnt_q <= fill_cnt_q + 1'b1;
               if (fill_last) state_q <= FS_IDLE;
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign mem_rd_req  = (state_q == FS_REQ);
   assign mem_rd_line = fill_line_q;

   // Fill words and store hits never coincide: a hit requires FS_IDLE.
   always_comb begin
      dwr_en   = fill_word || store_done;
      dwr_idx  = fill_word ? fill_line_q[IDX_W-1:0] : a_idx;
      dwr_word = fill_word ? fill_cnt_q : a_word;
      dwr_data = fill_word ? mem_rd_data : cpu_wdata;
   end

   cache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (a_idx),
      .rd_valid (line_valid),
      .rd_tag   (line_tag),
      .inv_en   (start_fill),
      .set_en   (fill_last),
      .wr_idx   (start_fill ? a_idx : fill_line_q[IDX_W-1:0]),
      .wr_tag   (fill_line_q[LINE_W-1 -: TAG_W])
   );

   cache_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .rd_idx  (a_idx),
      .rd_word (a_word),
      .rd_data (cpu_rdata),
      .wr_en   (dwr_en),
      .wr_idx  (dwr_idx),
      .wr_word (dwr_word),
      .wr_data (dwr_data)
   );

   assign wq_in.addr = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign wq_in.data = cpu_wdata;
   assign mem_wr_req = !wq_empty && (state_q == FS_IDLE);
   assign wq_pop     = mem_wr_req && mem_wr_ack;
   assign mem_wr_addr = wq_head.addr;
   assign mem_wr_data = wq_head.data;

   cache_wq #(.DEPTH(WQ_DEPTH), .W($bits(wq_entry_t))) u_wq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (store_done),
      .push_data (wq_in),
      .pop       (wq_pop),
      .head      (wq_head),
      .full      (wq_full),
      .empty     (wq_empty)
   );

   AST_RD_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req && mem_rd_busy |=> mem_rd_req && $stable(mem_rd_line)); // R4
   AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req || state_q == FS_FILL) |-> !mem_wr_req); // R9
   AST_FILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && state_q != FS_IDLE |-> cpu_stall); // R5
   AST_REPLAY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      fill_last |=> (!cpu_req || cpu_addr[ADDR_W-1 -: LINE_W] != $past(fill_line_q)
                     || !cpu_stall)); // R5
endmodule

// File: tb/dm_wt_cache_tb.sv
`timescale 1ns/1ps
module dm_wt_cache_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cpu_req, cpu_we;
   logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
   logic        cpu_stall;
   logic        mem_rd_req;
   logic [25:0] mem_rd_line;
   logic        mem_rd_busy, mem_rd_valid;
   logic [31:0] mem_rd_data;
   logic        mem_wr_req, mem_wr_ack;
   logic [31:0] mem_wr_addr, mem_wr_data;
   logic        ack_en;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   dm_wt_cache u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_stall(cpu_stall), .mem_rd_req(mem_rd_req), .mem_rd_line(mem_rd_line),
      .mem_rd_busy(mem_rd_busy), .mem_rd_valid(mem_rd_valid),
      .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
   );

   assign mem_wr_ack = mem_wr_req & ack_en;

   // ---------------- memory model ----------------
   logic [31:0] mem_ovr [logic [31:0]];
   logic [31:0] ref_ovr [logic [31:0]];
   logic [31:0] wlog_a [0:63];
   logic [31:0] wlog_d [0:63];
   int          wlog_n = 0;
   int          mst = 0, mt = 0, mk = 0;
   logic [25:0] mline;
   logic [25:0] seen_line;
   int          rd_req_cycles = 0;
   int          port_clash = 0;

   function automatic logic [31:0] base_val(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
   endfunction

   function automatic logic [31:0] mread(input logic [31:0] a);
      if (mem_ovr.exists(a)) return mem_ovr[a];
      return base_val(a);
   endfunction

   function automatic logic [31:0] expect_val(input logic [31:0] a);
      logic [31:0] w;
      w = {a[31:2], 2'b00};
      if (ref_ovr.exists(w)) return ref_ovr[w];
      return base_val(w);
   endfunction

   initial begin
      mem_rd_busy  = 1'b1;
      mem_rd_valid = 1'b0;
      mem_rd_data  = '0;
   end

   always @(posedge clk) begin
      mem_rd_valid <= 1'b0;
      case (mst)
         0: if (mem_rd_req) begin mt <= 2; mst <= 1; end
         1: if (mt == 0) begin mem_rd_busy <= 1'b0; mst <= 2; end else mt <= mt - 1;
         2: begin mem_rd_busy <= 1'b1; mline <= mem_rd_line; mt <= 4; mk <= 0; mst <= 3; end
         3: if (mt == 0) mst <= 4; else mt <= mt - 1;
         4: begin
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= mread({mline, mk[3:0], 2'b00});
            mk  <= mk + 1;
            mst <= 5;
         end
         5: mst <= (mk == 16) ? 0 : 4;
         default: mst <= 0;
      endcase
      if (mem_wr_req && mem_wr_ack) begin
         mem_ovr[mem_wr_addr] = mem_wr_data;
         if (wlog_n < 64) begin
            wlog_a[wlog_n] = mem_wr_addr;
            wlog_d[wlog_n] = mem_wr_data;
         end
         wlog_n++;
      end
   end

   always @(negedge clk) begin
      if (mem_rd_req) begin seen_line = mem_rd_line; rd_req_cycles++; end
      if (mem_wr_req && (mst != 0 || mem_rd_req)) port_clash++;
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output int cyc);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cyc = 0;
      #1;
      while (cpu_stall && cyc < 5000) begin
         @(negedge clk); #1; cyc++;
      end
      rd = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic store(input logic [31:0] a, input logic [31:0] d, output int cyc);
      logic [31:0] rd;
      access(1'b1, a, d, rd, cyc);
      ref_ovr[{a[31:2], 2'b00}] = d;
   endtask

   // vector: we(1) addr(32) wdata(32) expect_hit(1)
   localparam int NV = 10;
   localparam logic [65:0] VEC [0:NV-1] = '{
      {1'b0, 32'h0000_1040, 32'h0,         1'b0},  // R1 first access misses
      {1'b0, 32'h0000_1044, 32'h0,         1'b1},  // R3 same line hits
      {1'b0, 32'h0000_107F, 32'h0,         1'b1},  // R2 byte bits ignored, word 15
      {1'b1, 32'h0000_1049, 32'hDEAD_BEEF, 1'b1},  // R6 store hit
      {1'b0, 32'h0000_1048, 32'h0,         1'b1},  // R6 read back
      {1'b0, 32'h0000_5040, 32'h0,         1'b0},  // R10 same index, other tag
      {1'b0, 32'h0000_1048, 32'h0,         1'b0},  // R10 evicted, refetch
      {1'b1, 32'h0002_0084, 32'h1234_5678, 1'b0},  // R7 store miss allocates
      {1'b0, 32'h0002_0084, 32'h0,         1'b1},  // R7 merged word
      {1'b0, 32'h0002_00BC, 32'h0,         1'b1}   // R7 rest of line from memory
   };

   bit finished = 1'b0;

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int cyc, base_n, rq0;
      cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0; ack_en = 1'b1;
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!cpu_stall && !mem_rd_req && !mem_wr_req, "R1 idle after reset",
          {29'd0, cpu_stall, mem_rd_req, mem_wr_req}, 32'd0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic        we, eh;
         logic [31:0] a, d;
         {we, a, d, eh} = VEC[i];
         rq0 = rd_req_cycles;
         if (we) begin
            store(a, d, cyc);
         end else begin
            access(1'b0, a, 32'h0, rd, cyc);
            chk(rd == expect_val(a), "R3 load data", rd, expect_val(a));
         end
         chk((cyc == 0) == eh, eh ? "R3 hit served with no stall" : "R1/R10 miss stalls",
             cyc, {31'd0, eh});
         if (!eh)
            chk(seen_line == a[31:6] && rd_req_cycles > rq0, "R4 burst line address",
                {6'd0, seen_line}, {6'd0, a[31:6]});
      end

      // R5: every word of a freshly filled line in its own slot
      access(1'b0, 32'h0900_0000, 32'h0, rd, cyc);
      for (int w = 1; w < 16; w++) begin
         logic [31:0] a;
         a = 32'h0900_0000 + 32'(w * 4);
         access(1'b0, a, 32'h0, rd, cyc);
         chk(rd == base_val(a) && cyc == 0, "R5 word placement", rd, base_val(a));
      end

      // R8: fill the queue with ack held off
      repeat (20) @(negedge clk);
      ack_en = 1'b0;
      base_n = wlog_n;
      for (int s = 0; s < 4; s++) begin
         store(32'h0900_0000 + 32'(s * 4), 32'hA000_0000 + 32'(s), cyc);
         chk(cyc == 0, "R8 store into non-full queue", cyc, 32'd0);
      end
      fork
         store(32'h0900_0010, 32'hA000_0004, cyc);
         begin repeat (6) @(negedge clk); ack_en = 1'b1; end
      join
      chk(cyc >= 5, "R8 store stalled on full queue", cyc, 32'd6);
      repeat (12) @(negedge clk);
      chk(wlog_n - base_n == 5, "R9 all queued writes drained", wlog_n - base_n, 32'd5);
      for (int s = 0; s < 5; s++)
         chk(wlog_a[base_n + s] == 32'h0900_0000 + 32'(s * 4) &&
             wlog_d[base_n + s] == 32'hA000_0000 + 32'(s),
             "R9 write order", wlog_a[base_n + s], 32'h0900_0000 + 32'(s * 4));

      // R9: miss waits for the queue to empty
      ack_en = 1'b0;
      store(32'h0900_0020, 32'hBEEF_0001, cyc);
      rq0 = rd_req_cycles;
      fork
         access(1'b0, 32'h0A00_0000, 32'h0, rd, cyc);
         begin
            repeat (8) @(negedge clk);
            chk(rd_req_cycles == rq0, "R9 fill held while queue busy",
                rd_req_cycles - rq0, 32'd0);
            ack_en = 1'b1;
         end
      join
      chk(rd == base_val(32'h0A00_0000), "R9 fill after drain", rd, base_val(32'h0A00_0000));
      chk(mem_ovr.exists(32'h0900_0020) && mem_ovr[32'h0900_0020] == 32'hBEEF_0001,
          "R6 write-through reached memory", wlog_d[wlog_n - 1], 32'hBEEF_0001);

      // R10: the stored line is refetched with its written word
      access(1'b0, 32'h0900_0020, 32'h0, rd, cyc);
      chk(rd == 32'hBEEF_0001, "R6 store hit readable", rd, 32'hBEEF_0001);
      access(1'b0, 32'h0909_0020, 32'h0, rd, cyc);  // same index, new tag
      access(1'b0, 32'h0900_0020, 32'h0, rd, cyc);
      chk(rd == 32'hBEEF_0001 && cyc > 0, "R10 refetch sees memory write", rd, 32'hBEEF_0001);

      chk(port_clash == 0, "R9 no write during fill", port_clash, 32'd0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule